// File: doc/BRIEF.md
# BT.656 stream parser and sample demultiplexer

This block takes the 8-bit byte stream of a digital component video link, with one byte per clock, and finds the timing reference codes embedded in it. A code is the three-byte preamble FF, 00, 00 followed by a status byte. Bit 4 of the status byte tells start-of-active-video apart from end-of-active-video. Bit 6 gives the field. Between a start code and the end of the active region, the interleaved 4:2:2 samples arrive in the order Cb, Y0, Cr, Y1. The block sorts them into parallel Cb, Y and Cr outputs.

Each complete four-byte group produces two pixels. The first is (Cb, Y0, Cr) and the second is (Cb, Y1, Cr). Each pixel is marked by a one-cycle valid strobe, and the strobes come two byte clocks apart, so pixels are delivered at half the byte rate. The field flag is latched only at a start code. A downstream line buffer or colour converter consumes the strobed pixels directly.

Top module: `bt656_rx`

## Requirements
- R1: While reset is asserted and after reset is released, with no start code seen: valid_o is 0; cb_o, y_o and cr_o are 0; and field_o is 0.
- R2: An active region opens only when a status byte with bit 4 = 0 directly follows the bytes FF, 00, 00. The status byte itself is not a sample. A partial preamble, an end code, or free-running data produces no valid strobe.
- R3: field_o takes bit 6 of the status byte of each start code (0 odd, 1 even). An end code leaves field_o unchanged.
- R4: Inside an active region, samples are assigned by a 2-bit phase in arrival order: phase 0 Cb, phase 1 Y0, phase 2 Cr, phase 3 Y1.
- R5: For a group whose Y1 byte is sampled at clock edge E, valid_o is high for the single cycle after E with (Cb, Y0, Cr). It is high again for the single cycle after edge E+2 with (Cb, Y1, Cr).
- R6: A line accepts at most ACTIVE_BYTES (default 1440) sample bytes, which is ACTIVE_BYTES/2 pixels. Later bytes are ignored until the next start code.
- R7: An end code (status bit 4 = 1) closes the active region. A group that is not complete when the region closes yields no pixel, and bytes after the end code yield none.
- R8: Every start code resets the sample phase to 0, even when it arrives in the middle of a group.
- R9: cb_o, y_o and cr_o change only in cycles where valid_o is high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Byte clock, one stream byte per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Incoming stream byte |
| cb_o | output | DATA_W | Blue-difference chroma of the current pixel |
| y_o | output | DATA_W | Luma of the current pixel |
| cr_o | output | DATA_W | Red-difference chroma of the current pixel |
| valid_o | output | 1 | One-cycle strobe when a new pixel is presented |
| field_o | output | 1 | Field flag latched at the latest start code |

## Verification
The assertions assume that sample bytes never form FF, 00, 00 by accident, so every detected preamble is a real code. They also assume that a start code is separated from the previous group's second pixel by at least the four bytes of its own code. The bench keeps all sample values between 0x10 and 0xEF, except where a test deliberately sends a preamble inside a line to probe the phase reset and the early-end case. Every code is placed at least four bytes after the last completed group, so strobes never collide and the per-line pixel count restarts cleanly at each start code.

// File: rtl/bt656_rx_pkg.sv
package bt656_rx_pkg;
  localparam int unsigned XY_H_BIT = 4;  // 0: start code, 1: end code
  localparam int unsigned XY_F_BIT = 6;  // field flag
  localparam int unsigned PRE_LEN  = 3;  // preamble bytes before the status byte

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } phase_e;
endpackage

// File: rtl/bt656_trs_det.sv
module bt656_trs_det
  import bt656_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              sav_o,
  output logic              eav_o,
  output logic              fld_o
);
  localparam int unsigned HW = PRE_LEN * DATA_W;

  logic [HW-1:0] hist_q;
  logic [HW-1:0] pre_pat;
  logic          pre_hit;

  // oldest byte at the top: FF then 00 then 00
  assign pre_pat = {{DATA_W{1'b1}}, {(HW - DATA_W){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[HW-DATA_W-1:0], data_i};
  end

  assign pre_hit = (hist_q == pre_pat);
  assign sav_o   = pre_hit & ~data_i[XY_H_BIT];
  assign eav_o   = pre_hit &  data_i[XY_H_BIT];
  assign fld_o   = data_i[XY_F_BIT];
endmodule

// File: rtl/bt656_line_gate.sv
module bt656_line_gate
  import bt656_rx_pkg::*;
#(
  parameter int unsigned ACTIVE_BYTES = 1440
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sav_i,
  input  logic   eav_i,
  input  logic   fld_i,
  output logic   take_o,
  output phase_e phase_o,
  output logic   field_o
);
  localparam int unsigned CW = $clog2(ACTIVE_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(ACTIVE_BYTES - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  phase_e        ph_q;
  logic          field_q;

  // the status byte of a code is never a sample
  assign take_o  = run_q & ~sav_i & ~eav_i;
  assign phase_o = ph_q;
  assign field_o = field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      ph_q    <= PH_CB;
      field_q <= 1'b0;
    end else if (sav_i) begin
      run_q   <= 1'b1;
      cnt_q   <= '0;
      ph_q    <= PH_CB;
      field_q <= fld_i;
    end else if (eav_i) begin
      run_q <= 1'b0;
    end else if (take_o) begin
      ph_q  <= phase_e'(ph_q + 2'd1);
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bt656_pack.sv
module bt656_pack
  import bt656_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  phase_e            phase_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] cb_o,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] cr_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] cb_q, y0_q, cr_q, y1_q;
  logic [1:0]        pend_q;
  logic              grp_done;

  assign grp_done = take_i & (phase_i == PH_Y1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cb_q <= '0;
      y0_q <= '0;
      cr_q <= '0;
    end else if (take_i) begin
      case (phase_i)
        PH_CB:   cb_q <= data_i;
        PH_Y0:   y0_q <= data_i;
        PH_CR:   cr_q <= data_i;
        default: ;
      endcase
    end
  end

  // second luma of a group goes out two cycles after the first pixel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      y1_q    <= '0;
      cb_o    <= '0;
      y_o     <= '0;
      cr_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      pend_q  <= {pend_q[0], grp_done};
      valid_o <= 1'b0;
      if (grp_done) begin
        cb_o    <= cb_q;
        y_o     <= y0_q;
        cr_o    <= cr_q;
        y1_q    <= data_i;
        valid_o <= 1'b1;
      end else if (pend_q[1]) begin
        y_o     <= y1_q;
        valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bt656_rx.sv
module bt656_rx
  import bt656_rx_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ACTIVE_BYTES = 1440
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] cb_o,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] cr_o,
  output logic              valid_o,
  output logic              field_o
);
  logic   sav_w, eav_w, fld_w, take_w;
  phase_e phase_w;

  bt656_trs_det #(.DATA_W(DATA_W)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .sav_o  (sav_w),
    .eav_o  (eav_w),
    .fld_o  (fld_w)
  );

  bt656_line_gate #(.ACTIVE_BYTES(ACTIVE_BYTES)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sav_i   (sav_w),
    .eav_i   (eav_w),
    .fld_i   (fld_w),
    .take_o  (take_w),
    .phase_o (phase_w),
    .field_o (field_o)
  );

  bt656_pack #(.DATA_W(DATA_W)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take_w),
    .phase_i (phase_w),
    .data_i  (data_i),
    .cb_o    (cb_o),
    .y_o     (y_o),
    .cr_o    (cr_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/bt656_rx_chk.sv
module bt656_rx_chk #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ACTIVE_BYTES = 1440
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sav_i,
  input logic              valid_i,
  input logic              field_i,
  input logic [DATA_W-1:0] cb_i,
  input logic [DATA_W-1:0] y_i,
  input logic [DATA_W-1:0] cr_i
);
  localparam int unsigned MAXP = ACTIVE_BYTES / 2;
  localparam int unsigned PW   = $clog2(MAXP + 2);

  logic          seen_q;
  logic [PW-1:0] pix_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q    <= 1'b0;
      pix_cnt_q <= '0;
    end else begin
      if (sav_i) seen_q <= 1'b1;
      if (sav_i) pix_cnt_q <= '0;
      else if (valid_i && pix_cnt_q != PW'(MAXP + 1)) pix_cnt_q <= pix_cnt_q + 1'b1;
    end
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);  // R5

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable({cb_i, y_i, cr_i}));  // R9

  AST_FIELD_AT_SAV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_i) |-> $past(sav_i));  // R3

  AST_NO_PIX_BEFORE_SAV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> seen_q);  // R2

  AST_LINE_PIX_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_cnt_q <= PW'(MAXP));  // R6
endmodule

bind bt656_rx bt656_rx_chk #(.DATA_W(DATA_W), .ACTIVE_BYTES(ACTIVE_BYTES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sav_i   (sav_w),
  .valid_i (valid_o),
  .field_i (field_o),
  .cb_i    (cb_o),
  .y_i     (y_o),
  .cr_i    (cr_o)
);

// File: tb/bt656_rx_bench.sv
module bt656_rx_bench;
  localparam int ACT = 1440;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data = 8'h10;
  logic [7:0] cb_o, y_o, cr_o;
  logic       valid_o, field_o;

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int pix_n = 0;
  int hold_err = 0;
  logic [7:0] pcb [1024];
  logic [7:0] py  [1024];
  logic [7:0] pcr [1024];
  int         pcy [1024];
  logic [23:0] prev_out = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bt656_rx u_bt656_rx (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data),
    .cb_o(cb_o), .y_o(y_o), .cr_o(cr_o), .valid_o(valid_o), .field_o(field_o)
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid_o) begin
        if (pix_n < 1024) begin
          pcb[pix_n] = cb_o; py[pix_n] = y_o; pcr[pix_n] = cr_o; pcy[pix_n] = cyc;
        end
        pix_n = pix_n + 1;
      end else if ({cb_o, y_o, cr_o} != prev_out) begin
        hold_err = hold_err + 1;
      end
      prev_out = {cb_o, y_o, cr_o};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    data = b;
  endtask

  task automatic code(input logic [7:0] xy);
    send(8'hFF); send(8'h00); send(8'h00); send(xy);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(8'h10);
  endtask

  // close any line, drain, clear capture
  task automatic fresh();
    code(8'h90);
    idle(8);
    pix_n = 0;
  endtask

  task automatic chk_pix(input string req, input int i,
                         input int ecb, input int ey, input int ecr);
    chk(pcb[i] == 8'(ecb), req, $sformatf("pix%0d cb", i), pcb[i], ecb);
    chk(py[i]  == 8'(ey),  req, $sformatf("pix%0d y", i),  py[i],  ey);
    chk(pcr[i] == 8'(ecr), req, $sformatf("pix%0d cr", i), pcr[i], ecr);
  endtask

  task automatic t_reset();
    chk(valid_o == 1'b0, "R1", "valid in reset", valid_o, 0);
    chk({cb_o, y_o, cr_o} == 24'd0, "R1", "data in reset", {cb_o, y_o, cr_o}, 0);
    @(negedge clk); rst_ni = 1'b1;
    idle(3);
    chk(valid_o == 1'b0, "R1", "valid after reset", valid_o, 0);
    chk({cb_o, y_o, cr_o} == 24'd0, "R1", "data after reset", {cb_o, y_o, cr_o}, 0);
    chk(field_o == 1'b0, "R1", "field after reset", field_o, 0);
  endtask

  task automatic t_no_sav();
    pix_n = 0;
    for (int i = 0; i < 16; i++) send(8'(8'h20 + i));
    send(8'hFF); send(8'h00); send(8'h80);          // partial preamble
    for (int i = 0; i < 8; i++) send(8'(8'h40 + i));
    code(8'hB0);                                     // end code
    for (int i = 0; i < 8; i++) send(8'(8'h50 + i));
    idle(4);
    chk(pix_n == 0, "R2", "pixels without start code", pix_n, 0);
  endtask

  task automatic t_basic();
    int c0;
    fresh();
    code(8'h80);
    for (int g = 0; g < 3; g++) begin
      send(8'(8'h20 + 4*g)); send(8'(8'h21 + 4*g));
      send(8'(8'h22 + 4*g)); send(8'(8'h23 + 4*g));
      if (g == 0) c0 = cyc;
    end
    code(8'h90);
    idle(6);
    chk(pix_n == 6, "R4", "pixel count 3 groups", pix_n, 6);
    for (int g = 0; g < 3; g++) begin
      chk_pix("R4", 2*g,   8'h20 + 4*g, 8'h21 + 4*g, 8'h22 + 4*g);
      chk_pix("R5", 2*g+1, 8'h20 + 4*g, 8'h23 + 4*g, 8'h22 + 4*g);
    end
    chk(pcy[0] == c0 + 1, "R5", "first pixel cycle", pcy[0], c0 + 1);
    chk(pcy[1] == c0 + 3, "R5", "second pixel cycle", pcy[1], c0 + 3);
    chk({cb_o, y_o, cr_o} == {8'h28, 8'h2B, 8'h2A}, "R9", "held after line",
        {cb_o, y_o, cr_o}, {8'h28, 8'h2B, 8'h2A});
  endtask

  task automatic t_field();
    fresh();
    code(8'hC0);
    send(8'h11);
    chk(field_o == 1'b1, "R3", "field after even start", field_o, 1);
    code(8'h90);                                     // end code, bit6 = 0
    idle(2);
    chk(field_o == 1'b1, "R3", "field after end code", field_o, 1);
    code(8'h80);
    send(8'h11);
    chk(field_o == 1'b0, "R3", "field after odd start", field_o, 0);
    code(8'h90);
    idle(4);
  endtask

  task automatic t_limit();
    fresh();
    code(8'h80);
    for (int i = 0; i < ACT + 8; i++) send(8'(16 + (i % 200)));
    idle(6);
    chk(pix_n == ACT/2, "R6", "pixels in full line", pix_n, ACT/2);
    chk_pix("R6", ACT/2 - 1, 16 + ((ACT-4) % 200), 16 + ((ACT-1) % 200),
            16 + ((ACT-2) % 200));
    code(8'h90);
    idle(4);
  endtask

  task automatic t_eav_early();
    fresh();
    code(8'h80);
    for (int i = 0; i < 8; i++) send(8'(8'h60 + i));
    code(8'h90);
    for (int i = 0; i < 4; i++) send(8'(8'h70 + i));
    idle(6);
    chk(pix_n == 4, "R7", "pixels after early end", pix_n, 4);
    chk_pix("R7", 3, 8'h64, 8'h67, 8'h66);
  endtask

  task automatic t_phase_reset();
    fresh();
    code(8'h80);
    send(8'hA0); send(8'hA1);
    code(8'h80);                                     // mid-group restart
    send(8'hC0); send(8'hC1); send(8'hC2); send(8'hC3);
    code(8'h90);
    idle(6);
    chk(pix_n == 4, "R8", "pixels around restart", pix_n, 4);
    chk_pix("R8", 0, 8'hA0, 8'hA1, 8'hFF);
    chk_pix("R8", 1, 8'hA0, 8'h00, 8'hFF);
    chk_pix("R8", 2, 8'hC0, 8'hC1, 8'hC2);
    chk_pix("R8", 3, 8'hC0, 8'hC3, 8'hC2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_no_sav();
    t_basic();
    t_field();
    t_limit();
    t_eav_early();
    t_phase_reset();
    chk(hold_err == 0, "R9", "output change without strobe", hold_err, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule